// File: doc/BRIEF.md
# Mode-Locked Identity and Secret Register Bank

This block is a 32-bit memory-mapped register bank for a small security token. It presents the token's identity material to the processor: an eight-word device secret, a four-word authentication key, a two-word device identifier, an eight-word compound identity computed by boot firmware, a pair of registers that describe where the application image was loaded, and read-only identification constants. The secret, key and identifier values arrive on input ports. The block exposes them, and it does not store or derive them.

After reset the bank is in firmware mode. Boot firmware reads each secret word once, derives the compound identity and writes it back, and records the application's load address and size. It then writes the mode-switch register. That write is one-way: the bank enters application mode and stays there until the next reset. In application mode the secret and the key read as faults, and the firmware-owned registers become read-only.

Each access completes in the cycle it is presented. Read data and the error flag are combinational from the request, and state changes at the next rising clock edge.

Top module: `secret_id_bank`

## Requirements
- R1: An access is accepted only if `req_size` is 2 (word) and `req_addr[1:0]` is 0. Any other access raises `rsp_err`, returns zero and changes no state, so it does not consume a secret word.
- R2: Reset leaves the bank in firmware mode, clears every secret read-once flag, and sets the load address, load size and compound identity words to zero.
- R3: Reading offset 0x00 returns 0x6d746131, offset 0x04 returns 0x6d6b6466 and offset 0x08 returns 1. Writes to these three offsets are rejected.
- R4: Secret word i sits at offset 0x40+4i. Its first read in firmware mode returns the word. Every later read of that word until reset is rejected and returns zero.
- R5: In application mode, reads of the secret (0x40–0x5C) and of the key (0x30–0x3C) are rejected and return zero.
- R6: In firmware mode, key word i reads at 0x30+4i. Identifier word i reads at 0x20+4i in either mode.
- R7: Writes to the identifier, key and secret ranges are always rejected.
- R8: Compound identity word i at 0x60+4i can be written only in firmware mode and can be read in either mode. A write in application mode is rejected and leaves the stored value unchanged.
- R9: A write to offset 0x0C in firmware mode is accepted and enters application mode. A second write to 0x0C is rejected, and a read of 0x0C is always rejected.
- R10: The load address (0x10) and load size (0x14) can be written only in firmware mode and can be read in either mode. A rejected write leaves the value unchanged.
- R11: A read or write to any offset outside the map is rejected and reads as zero.
- R12: `rsp_err` is high only in a cycle where `req_valid` is high and the access is rejected. A rejected access always returns zero on `rsp_rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access strobe for this cycle |
| req_we | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | Access size: 0 byte, 1 half, 2 word |
| req_addr | input | ADDR_W | Byte offset within the bank |
| req_wdata | input | 32 | Write data |
| secret_words_i | input | 32*SEC_WORDS | Device secret, word i in bits [32i+31:32i] |
| key_words_i | input | 32*KEY_WORDS | Authentication key words |
| devid_words_i | input | 32*ID_WORDS | Device identifier words |
| rsp_rdata | output | 32 | Read data, zero on reject or on write |
| rsp_err | output | 1 | Rejected-access pulse in the access cycle |

## Verification
Properties are checked on every cycle. One says a malformed access and any access while in application mode to a secret word raise the error with zero data. Another says the error never rises without a request. Others say application mode never falls back without reset, and the load and identity registers hold steady once the mode is locked. Read-once flags may rise only on a granted read and never clear outside reset. Only the bench's scenarios can show what comes back from each location. It checks that a malformed read leaves a secret word unconsumed, that rejected writes leave stored values intact, and that reset makes every secret word readable again. It runs these checks under random access mixes across several reset epochs.

// File: rtl/sidb_pkg.sv
package sidb_pkg;

    localparam int unsigned WORD_W = 32;

    localparam logic [1:0]  SZ_WORD      = 2'd2;
    localparam logic [31:0] NAME_LO_VAL  = 32'h6d746131;
    localparam logic [31:0] NAME_HI_VAL  = 32'h6d6b6466;
    localparam logic [31:0] VERSION_VAL  = 32'd1;

    localparam logic [31:0] OFS_NAME_LO  = 32'h00;
    localparam logic [31:0] OFS_NAME_HI  = 32'h04;
    localparam logic [31:0] OFS_VERSION  = 32'h08;
    localparam logic [31:0] OFS_LOCK     = 32'h0C;
    localparam logic [31:0] OFS_LADDR    = 32'h10;
    localparam logic [31:0] OFS_LSIZE    = 32'h14;
    localparam logic [31:0] OFS_DEVID    = 32'h20;
    localparam logic [31:0] OFS_KEY      = 32'h30;
    localparam logic [31:0] OFS_SECRET   = 32'h40;
    localparam logic [31:0] OFS_CIDN     = 32'h60;

    typedef enum logic [3:0] {
        RG_NONE,
        RG_NAME_LO,
        RG_NAME_HI,
        RG_VERSION,
        RG_LOCK,
        RG_LADDR,
        RG_LSIZE,
        RG_DEVID,
        RG_KEY,
        RG_SECRET,
        RG_CIDN
    } region_e;

    typedef struct packed {
        region_e    region;
        logic [4:0] idx;
    } hit_t;

    typedef struct packed {
        logic              ok;
        logic [WORD_W-1:0] data;
    } rsp_t;

    function automatic logic in_window(input logic [31:0] a, input logic [31:0] base,
                                       input int unsigned n);
        return (a >= base) && (a < base + 32'(4 * n));
    endfunction

    function automatic logic [4:0] word_index(input logic [31:0] a, input logic [31:0] base);
        logic [31:0] d;
        d = (a - base) >> 2;
        return d[4:0];
    endfunction

    function automatic hit_t decode_addr(input logic [31:0] a,
                                         input int unsigned n_id, input int unsigned n_key,
                                         input int unsigned n_sec, input int unsigned n_cid);
        hit_t h;
        h.region = RG_NONE;
        h.idx    = '0;
        if (a == OFS_NAME_LO)                     h.region = RG_NAME_LO;
        else if (a == OFS_NAME_HI)                h.region = RG_NAME_HI;
        else if (a == OFS_VERSION)                h.region = RG_VERSION;
        else if (a == OFS_LOCK)                   h.region = RG_LOCK;
        else if (a == OFS_LADDR)                  h.region = RG_LADDR;
        else if (a == OFS_LSIZE)                  h.region = RG_LSIZE;
        else if (in_window(a, OFS_DEVID, n_id)) begin
            h.region = RG_DEVID;
            h.idx    = word_index(a, OFS_DEVID);
        end else if (in_window(a, OFS_KEY, n_key)) begin
            h.region = RG_KEY;
            h.idx    = word_index(a, OFS_KEY);
        end else if (in_window(a, OFS_SECRET, n_sec)) begin
            h.region = RG_SECRET;
            h.idx    = word_index(a, OFS_SECRET);
        end else if (in_window(a, OFS_CIDN, n_cid)) begin
            h.region = RG_CIDN;
            h.idx    = word_index(a, OFS_CIDN);
        end
        return h;
    endfunction

endpackage

// File: rtl/sidb_decode.sv
module sidb_decode
    import sidb_pkg::*;
#(
    parameter int unsigned ADDR_W    = 8,
    parameter int unsigned ID_WORDS  = 2,
    parameter int unsigned KEY_WORDS = 4,
    parameter int unsigned SEC_WORDS = 8,
    parameter int unsigned CID_WORDS = 8
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        size,
    output logic              shape_ok,
    output hit_t              hit
);

    always_comb begin
        shape_ok = (size == SZ_WORD) && (addr[1:0] == 2'b00);
        hit      = decode_addr(32'(addr), ID_WORDS, KEY_WORDS, SEC_WORDS, CID_WORDS);
    end

endmodule

// File: rtl/sidb_once_gate.sv
module sidb_once_gate #(
    parameter int unsigned N     = 8,
    localparam int unsigned IX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            rd_try,
    input  logic [IX_W-1:0] idx,
    input  logic            locked,
    output logic            grant
);

    logic [N-1:0] used_q;

    assign grant = rd_try && !locked && !used_q[idx];

    for (genvar i = 0; i < N; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst)
                used_q[i] <= 1'b0;
            else if (grant && (idx == IX_W'(i)))
                used_q[i] <= 1'b1;
        end

        // R4: a consumed word stays consumed until reset
        assert_once_sticky_R4: assert property (@(posedge clk) disable iff (rst)
            used_q[i] |=> used_q[i]);

        // R4: a flag rises only after a granted read of its own word
        assert_once_cause_R4: assert property (@(posedge clk) disable iff (rst)
            $rose(used_q[i]) |-> $past(rd_try && !locked && idx == IX_W'(i)));
    end

    // R5: nothing is granted while locked
    assert_no_grant_locked_R5: assert property (@(posedge clk) disable iff (rst)
        locked |-> !grant);

endmodule

// File: rtl/sidb_state.sv
module sidb_state
    import sidb_pkg::*;
#(
    parameter int unsigned CID_WORDS = 8,
    localparam int unsigned CX_W     = (CID_WORDS > 1) ? $clog2(CID_WORDS) : 1
) (
    input  logic                                clk,
    input  logic                                rst,
    input  logic                                lock_set,
    input  logic                                laddr_we,
    input  logic                                lsize_we,
    input  logic                                cid_we,
    input  logic [CX_W-1:0]                     cid_idx,
    input  logic [WORD_W-1:0]                   wdata,
    output logic                                app_mode,
    output logic [WORD_W-1:0]                   load_addr,
    output logic [WORD_W-1:0]                   load_size,
    output logic [CID_WORDS-1:0][WORD_W-1:0]    cid_q
);

    always_ff @(posedge clk) begin
        if (rst)           app_mode <= 1'b0;
        else if (lock_set) app_mode <= 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            load_addr <= '0;
            load_size <= '0;
        end else begin
            if (laddr_we) load_addr <= wdata;
            if (lsize_we) load_size <= wdata;
        end
    end

    for (genvar i = 0; i < CID_WORDS; i++) begin : g_cid
        always_ff @(posedge clk) begin
            if (rst)
                cid_q[i] <= '0;
            else if (cid_we && (cid_idx == CX_W'(i)))
                cid_q[i] <= wdata;
        end

        // R8: identity words are frozen in application mode
        assert_cid_frozen_R8: assert property (@(posedge clk) disable iff (rst)
            app_mode |=> $stable(cid_q[i]));
    end

    // R9: application mode is one-way until reset
    assert_mode_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        app_mode |=> app_mode);

    // R10: load registers are frozen in application mode
    assert_load_frozen_R10: assert property (@(posedge clk) disable iff (rst)
        app_mode |=> ($stable(load_addr) && $stable(load_size)));

endmodule

// File: rtl/secret_id_bank.sv
module secret_id_bank
    import sidb_pkg::*;
#(
    parameter int unsigned ADDR_W    = 8,
    parameter int unsigned SEC_WORDS = 8,
    parameter int unsigned KEY_WORDS = 4,
    parameter int unsigned ID_WORDS  = 2,
    parameter int unsigned CID_WORDS = 8
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          req_valid,
    input  logic                          req_we,
    input  logic [1:0]                    req_size,
    input  logic [ADDR_W-1:0]             req_addr,
    input  logic [31:0]                   req_wdata,
    input  logic [32*SEC_WORDS-1:0]       secret_words_i,
    input  logic [32*KEY_WORDS-1:0]       key_words_i,
    input  logic [32*ID_WORDS-1:0]        devid_words_i,
    output logic [31:0]                   rsp_rdata,
    output logic                          rsp_err
);

    localparam int unsigned SX_W = (SEC_WORDS > 1) ? $clog2(SEC_WORDS) : 1;
    localparam int unsigned CX_W = (CID_WORDS > 1) ? $clog2(CID_WORDS) : 1;

    logic shape_ok;
    hit_t hit;
    logic rd, wr;
    logic sec_try, sec_grant;
    logic lock_set, laddr_we, lsize_we, cid_we;
    logic app_mode;
    logic [WORD_W-1:0] load_addr, load_size;
    logic [CID_WORDS-1:0][WORD_W-1:0] cid_q;
    rsp_t rsp;

    sidb_decode #(
        .ADDR_W    (ADDR_W),
        .ID_WORDS  (ID_WORDS),
        .KEY_WORDS (KEY_WORDS),
        .SEC_WORDS (SEC_WORDS),
        .CID_WORDS (CID_WORDS)
    ) u_decode (
        .addr     (req_addr),
        .size     (req_size),
        .shape_ok (shape_ok),
        .hit      (hit)
    );

    assign rd      = req_valid && !req_we && shape_ok;
    assign wr      = req_valid &&  req_we && shape_ok;
    assign sec_try = rd && (hit.region == RG_SECRET);

    sidb_once_gate #(.N(SEC_WORDS)) u_once (
        .clk    (clk),
        .rst    (rst),
        .rd_try (sec_try),
        .idx    (hit.idx[SX_W-1:0]),
        .locked (app_mode),
        .grant  (sec_grant)
    );

    sidb_state #(.CID_WORDS(CID_WORDS)) u_state (
        .clk       (clk),
        .rst       (rst),
        .lock_set  (lock_set),
        .laddr_we  (laddr_we),
        .lsize_we  (lsize_we),
        .cid_we    (cid_we),
        .cid_idx   (hit.idx[CX_W-1:0]),
        .wdata     (req_wdata),
        .app_mode  (app_mode),
        .load_addr (load_addr),
        .load_size (load_size),
        .cid_q     (cid_q)
    );

    always_comb begin
        rsp      = '0;
        lock_set = 1'b0;
        laddr_we = 1'b0;
        lsize_we = 1'b0;
        cid_we   = 1'b0;
        unique case (hit.region)
            RG_NAME_LO: if (rd) rsp = '{ok: 1'b1, data: NAME_LO_VAL};
            RG_NAME_HI: if (rd) rsp = '{ok: 1'b1, data: NAME_HI_VAL};
            RG_VERSION: if (rd) rsp = '{ok: 1'b1, data: VERSION_VAL};
            RG_LOCK: if (wr && !app_mode) begin
                rsp.ok   = 1'b1;
                lock_set = 1'b1;
            end
            RG_LADDR: begin
                if (rd) rsp = '{ok: 1'b1, data: load_addr};
                else if (wr && !app_mode) begin
                    rsp.ok   = 1'b1;
                    laddr_we = 1'b1;
                end
            end
            RG_LSIZE: begin
                if (rd) rsp = '{ok: 1'b1, data: load_size};
                else if (wr && !app_mode) begin
                    rsp.ok   = 1'b1;
                    lsize_we = 1'b1;
                end
            end
            RG_DEVID: if (rd)
                rsp = '{ok: 1'b1, data: devid_words_i[32*int'(hit.idx) +: 32]};
            RG_KEY: if (rd && !app_mode)
                rsp = '{ok: 1'b1, data: key_words_i[32*int'(hit.idx) +: 32]};
            RG_SECRET: if (sec_grant)
                rsp = '{ok: 1'b1, data: secret_words_i[32*int'(hit.idx) +: 32]};
            RG_CIDN: begin
                if (rd) rsp = '{ok: 1'b1, data: cid_q[hit.idx[CX_W-1:0]]};
                else if (wr && !app_mode) begin
                    rsp.ok = 1'b1;
                    cid_we = 1'b1;
                end
            end
            default: rsp = '0;
        endcase
    end

    assign rsp_err   = req_valid && !rsp.ok;
    assign rsp_rdata = rsp.data;

    // R1: malformed accesses are rejected
    assert_shape_reject_R1: assert property (@(posedge clk) disable iff (rst)
        (req_valid && (req_size != SZ_WORD || req_addr[1:0] != 2'b00)) |-> rsp_err);

    // R12: rejected accesses carry zero data
    assert_reject_zero_R12: assert property (@(posedge clk) disable iff (rst)
        rsp_err |-> (rsp_rdata == 32'd0));

    // R12: no error without a request
    assert_err_needs_req_R12: assert property (@(posedge clk) disable iff (rst)
        !req_valid |-> !rsp_err);

    // R5: secret and key reads fault in application mode
    assert_app_secret_fault_R5: assert property (@(posedge clk) disable iff (rst)
        (rd && app_mode && (hit.region == RG_SECRET || hit.region == RG_KEY)) |-> rsp_err);

    // R11: unmapped offsets fault
    assert_unmapped_R11: assert property (@(posedge clk) disable iff (rst)
        (req_valid && hit.region == RG_NONE) |-> rsp_err);

endmodule

// File: tb/secret_id_bank_test.sv
module secret_id_bank_test;

    localparam int NSEC = 8;
    localparam int NKEY = 4;
    localparam int NID  = 2;
    localparam int NCID = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid = 1'b0;
    logic req_we = 1'b0;
    logic [1:0] req_size = 2'd2;
    logic [7:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic [32*NSEC-1:0] secret_words;
    logic [32*NKEY-1:0] key_words;
    logic [32*NID-1:0]  devid_words;
    logic [31:0] rsp_rdata;
    logic rsp_err;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    function automatic logic [31:0] sec_val(input int i);
        return 32'h80808080 + 32'(i) * 32'h11111111;
    endfunction
    function automatic logic [31:0] key_val(input int i);
        return 32'h0000beef + 32'(i + 1) * 32'h10000000;
    endfunction
    function automatic logic [31:0] id_val(input int i);
        return 32'hd0d00000 + 32'(i + 1);
    endfunction

    initial begin
        for (int i = 0; i < NSEC; i++) secret_words[32*i +: 32] = sec_val(i);
        for (int i = 0; i < NKEY; i++) key_words[32*i +: 32]    = key_val(i);
        for (int i = 0; i < NID;  i++) devid_words[32*i +: 32]  = id_val(i);
    end

    secret_id_bank uut (
        .clk            (clk),
        .rst            (rst),
        .req_valid      (req_valid),
        .req_we         (req_we),
        .req_size       (req_size),
        .req_addr       (req_addr),
        .req_wdata      (req_wdata),
        .secret_words_i (secret_words),
        .key_words_i    (key_words),
        .devid_words_i  (devid_words),
        .rsp_rdata      (rsp_rdata),
        .rsp_err        (rsp_err)
    );

    // reference model state
    logic        m_app;
    logic [7:0]  m_used;
    logic [31:0] m_cid [NCID];
    logic [31:0] m_laddr, m_lsize;

    task automatic model_reset();
        m_app = 1'b0;
        m_used = '0;
        for (int i = 0; i < NCID; i++) m_cid[i] = '0;
        m_laddr = '0;
        m_lsize = '0;
    endtask

    task automatic model_step(input logic we, input logic [7:0] a, input logic [1:0] sz,
                              input logic [31:0] wd, output logic xe,
                              output logic [31:0] xd, output string tag);
        int w;
        xe = 1'b1; xd = '0; tag = "R11";
        w = int'(a) / 4;
        if (sz != 2'd2 || a[1:0] != 2'b00) begin tag = "R1"; return; end
        if (!we) begin
            if (a == 8'h00) begin xe = 0; xd = 32'h6d746131; tag = "R3"; end
            else if (a == 8'h04) begin xe = 0; xd = 32'h6d6b6466; tag = "R3"; end
            else if (a == 8'h08) begin xe = 0; xd = 32'd1; tag = "R3"; end
            else if (a == 8'h0C) tag = "R9";
            else if (a == 8'h10) begin xe = 0; xd = m_laddr; tag = "R10"; end
            else if (a == 8'h14) begin xe = 0; xd = m_lsize; tag = "R10"; end
            else if (a >= 8'h20 && a < 8'h28) begin xe = 0; xd = id_val(w - 8); tag = "R6"; end
            else if (a >= 8'h30 && a < 8'h40) begin
                if (m_app) tag = "R5";
                else begin xe = 0; xd = key_val(w - 12); tag = "R6"; end
            end else if (a >= 8'h40 && a < 8'h60) begin
                if (m_app) tag = "R5";
                else begin
                    tag = "R4";
                    if (!m_used[w - 16]) begin
                        xe = 0; xd = sec_val(w - 16); m_used[w - 16] = 1'b1;
                    end
                end
            end else if (a >= 8'h60 && a < 8'h80) begin xe = 0; xd = m_cid[w - 24]; tag = "R8"; end
        end else begin
            if (a == 8'h00 || a == 8'h04 || a == 8'h08) tag = "R3";
            else if (a == 8'h0C) begin
                tag = "R9";
                if (!m_app) begin xe = 0; m_app = 1'b1; end
            end else if (a == 8'h10) begin
                tag = "R10";
                if (!m_app) begin xe = 0; m_laddr = wd; end
            end else if (a == 8'h14) begin
                tag = "R10";
                if (!m_app) begin xe = 0; m_lsize = wd; end
            end else if ((a >= 8'h20 && a < 8'h28) || (a >= 8'h30 && a < 8'h60)) tag = "R7";
            else if (a >= 8'h60 && a < 8'h80) begin
                tag = "R8";
                if (!m_app) begin xe = 0; m_cid[w - 24] = wd; end
            end
        end
    endtask

    task automatic check(input string tag, input logic [31:0] got_d, input logic got_e,
                         input logic [31:0] exp_d, input logic exp_e);
        checks++;
        if (got_d !== exp_d || got_e !== exp_e) begin
            errors++;
            $display("FAIL %s: rdata=%h err=%b expected rdata=%h err=%b",
                     tag, got_d, got_e, exp_d, exp_e);
        end
    endtask

    task automatic access(input logic we, input logic [7:0] a, input logic [1:0] sz,
                          input logic [31:0] wd);
        logic xe;
        logic [31:0] xd;
        string tag;
        model_step(we, a, sz, wd, xe, xd, tag);
        @(negedge clk);
        req_valid = 1'b1; req_we = we; req_addr = a; req_size = sz; req_wdata = wd;
        #1;
        check(tag, rsp_rdata, rsp_err, xd, xe);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0; req_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a);
        access(1'b0, a, 2'd2, 32'd0);
    endtask
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        access(1'b1, a, 2'd2, d);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; req_valid = 1'b0;
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        model_reset();
    endtask

    initial begin
        #800000;
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: rdata=%h err=%b expected rdata=%h err=%b",
                     rsp_rdata, rsp_err, 32'd0, 1'b0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        model_reset();
        do_reset();

        // R2: reset state
        rd(8'h10); rd(8'h14); rd(8'h60); rd(8'h7C);
        // R3: constants, writes rejected
        rd(8'h00); rd(8'h04); rd(8'h08); wr(8'h00, 32'h1); rd(8'h00);
        // R1: malformed accesses do not consume a secret word
        rd(8'h41); access(1'b0, 8'h40, 2'd1, 0); access(1'b0, 8'h40, 2'd0, 0);
        // R4: first read returns, second faults
        rd(8'h40); rd(8'h40); rd(8'h5C); rd(8'h5C);
        // R6: key and identifier
        rd(8'h30); rd(8'h3C); rd(8'h20); rd(8'h24);
        // R7: read-only ranges
        wr(8'h44, 32'hdead); wr(8'h34, 32'hdead); wr(8'h20, 32'hdead);
        rd(8'h44); rd(8'h34); rd(8'h20);
        // R8 / R10: firmware writes
        wr(8'h60, 32'h11223344); wr(8'h7C, 32'h55667788); rd(8'h60); rd(8'h7C);
        wr(8'h10, 32'h00012000); wr(8'h14, 32'h00000400); rd(8'h10); rd(8'h14);
        // R9: lock register
        rd(8'h0C); wr(8'h0C, 32'h1);
        // R5: application mode faults
        rd(8'h48); rd(8'h30); rd(8'h24);
        // R8 / R10 / R9 in application mode
        wr(8'h60, 32'hffffffff); rd(8'h60); wr(8'h10, 32'h0); rd(8'h10);
        wr(8'h14, 32'h0); rd(8'h14); wr(8'h0C, 32'h1); rd(8'h48);
        // R11: unmapped
        rd(8'h18); rd(8'h28); wr(8'hF0, 32'h5); rd(8'hF0);
        // R12: idle cycle
        @(negedge clk); req_valid = 1'b0; #1;
        check("R12", rsp_rdata, rsp_err, 32'd0, 1'b0);
        // R2: reset restores secret access and firmware mode
        do_reset();
        rd(8'h40); rd(8'h60); wr(8'h60, 32'h9); rd(8'h60);

        // random epochs
        for (int ep = 0; ep < 4; ep++) begin
            do_reset();
            for (int n = 0; n < 200; n++) begin
                logic [7:0] a;
                logic [1:0] sz;
                logic we;
                if ($urandom % 10 == 0) a = 8'($urandom);
                else a = {1'b0, 5'($urandom), 2'b00};
                sz = ($urandom % 8 == 0) ? 2'($urandom) : 2'd2;
                we = 1'($urandom);
                if (a == 8'h0C && we && ($urandom % 4 != 0) && n < 120) we = 1'b0;
                access(we, a, sz, $urandom);
            end
        end

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule